// File: doc/BRIEF.md
# Thermal Sensor Round Controller

This block runs measurement rounds across five temperature evaluator units. Four of them sit in compute cores and handle eight remote sensors each. The fifth sits in the hub and handles six. On a periodic tick or a start pulse, the controller sends one collect pulse to all evaluators at once. It then takes their reports over a valid/ready handshake. Each evaluator converts its sensors one after another, so its reports come in one at a time, and reports from different evaluators can interleave in any order.

Each report names an evaluator, a sensor and a 9-bit temperature code. Accepted codes go into a reading table, which is read through a combinational address port. A round ends in one of two ways. It completes once all 38 expected (evaluator, sensor) pairs have arrived, or it ends early when a programmable cycle budget runs out. At the end of a round the controller publishes the largest code each evaluator reported during that round, and a flag for every evaluator that left readings missing. A sticky alarm rises as soon as any accepted code reaches the programmable threshold. Reports that name a nonexistent evaluator or sensor are discarded and raise a protocol error flag.

Top module: `thermo_poll_ctrl`

## Requirements
- R1: When idle, a high `tick_i` or `start_i` at a clock edge starts a round. `collect_o` (all five bits) is high for exactly the one cycle after that edge, and `busy_o` is high from that cycle until the round ends.
- R2: `tick_i` and `start_i` are ignored while `busy_o` is high. No collect pulse is produced and the running round is not restarted.
- R3: `rpt_ready_o` is high only while a round runs. A report is taken at an edge where `rpt_valid_i` and `rpt_ready_o` are both high. From the next cycle its code reads back on `rd_code_o` when `rd_unit_i`/`rd_sensor_i` address it.
- R4: A taken report is invalid if its evaluator index is 5 or more, or if it names the hub evaluator (index 4) with a sensor index of 6 or 7. An invalid report is not stored, does not count toward completion, and sets `proto_err_o` from the next cycle. `proto_err_o` stays set until the next round starts.
- R5: A round completes once every pair has been stored: evaluators 0–3 with sensors 0–7, and evaluator 4 with sensors 0–5. `done_o` is high for the single cycle that follows the edge after the last needed report, and `busy_o` falls in that same cycle.
- R6: In the cycle `done_o` is high and afterwards, `max_o[u*9 +: 9]` holds the largest code stored from evaluator u during the round that just ended, or 0 if that evaluator stored nothing. Evaluator 0 occupies the low bits.
- R7: If a round is still incomplete after `timeout_i` cycles, counted from the cycle `collect_o` is high, it ends. `done_o` is high exactly `timeout_i` cycles after the collect cycle. Bit u of `tmo_o` is set for each evaluator u that is still missing readings. `tmo_o` is cleared when the next round starts and is 0 after a completed round.
- R8: `alarm_o` is set from the cycle after a valid report with a code greater than or equal to `thresh_i` is taken. A code equal to the threshold counts. Invalid reports never set the alarm, and once set it stays high until reset.
- R9: While reset is asserted and right after it, `busy_o`, `collect_o`, `rpt_ready_o`, `done_o`, `tmo_o`, `max_o`, `proto_err_o` and `alarm_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Periodic round request |
| start_i | input | 1 | Software round request |
| timeout_i | input | 16 | Round cycle budget; hold stable while busy |
| thresh_i | input | 9 | Over-temperature threshold |
| collect_o | output | 5 | Collect command, one bit per evaluator |
| rpt_valid_i | input | 1 | Report valid |
| rpt_ready_o | output | 1 | Report ready |
| rpt_unit_i | input | 3 | Reporting evaluator index |
| rpt_sensor_i | input | 3 | Sensor index within that evaluator |
| rpt_code_i | input | 9 | Temperature code |
| rd_unit_i | input | 3 | Table read evaluator index |
| rd_sensor_i | input | 3 | Table read sensor index |
| rd_code_o | output | 9 | Stored code at the read address, 0 if out of range |
| busy_o | output | 1 | Round in progress |
| done_o | output | 1 | One-cycle round end pulse |
| tmo_o | output | 5 | Evaluators missing readings at timeout |
| max_o | output | 45 | Per-evaluator round maximum, 9 bits each |
| proto_err_o | output | 1 | Invalid report seen this round |
| alarm_o | output | 1 | Sticky over-temperature alarm |

## Verification
The collect pulse and `rpt_ready_o` are sampled in the cycle right after the trigger edge. A stored reading and a raised error or alarm flag are each sampled one cycle after the accepting edge. `done_o`, `max_o` and `tmo_o` are due two edges after the final needed report, or exactly `timeout_i` cycles after the collect cycle. The bench drives every input at the falling edge and samples just after it. It checks `done_o` low one cycle before the due cycle and high in it. A free-running cycle counter measures the timeout distance. A scoreboard queue holds every stored report and is drained against the read port only once `done_o` has been seen.

// File: rtl/thermo_poll_pkg.sv
package thermo_poll_pkg;

  typedef enum logic {TP_IDLE = 1'b0, TP_RUN = 1'b1} tp_state_e;

  // Number of sensors behind evaluator u: core units first, hub last.
  function automatic int unsigned tp_sensors_of(int unsigned u, int unsigned core_units,
                                                int unsigned core_sens, int unsigned hub_sens);
    if (u < core_units) return core_sens;
    if (u == core_units) return hub_sens;
    return 0;
  endfunction

  // True when (u, s) is a pair the round must collect.
  function automatic logic tp_pair_wanted(int unsigned u, int unsigned s, int unsigned core_units,
                                          int unsigned core_sens, int unsigned hub_sens);
    return s < tp_sensors_of(u, core_units, core_sens, hub_sens);
  endfunction

  // Remaining-budget test: true on the last cycle allowed by the budget.
  function automatic logic tp_budget_spent(int unsigned elapsed, int unsigned budget);
    return (elapsed + 1) >= budget;
  endfunction

endpackage

// File: rtl/tp_round_fsm.sv
module tp_round_fsm
  import thermo_poll_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger_i,
  input  logic             full_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             start_evt_o,
  output logic             end_evt_o,
  output logic             run_o,
  output logic             collect_o,
  output logic             done_o
);

  tp_state_e        state_q;
  logic [TMO_W-1:0] cnt_q;
  logic             collect_q, done_q;
  logic             budget_out;

  assign budget_out  = tp_budget_spent(32'(cnt_q), 32'(timeout_i));
  assign start_evt_o = (state_q == TP_IDLE) && trigger_i;
  assign end_evt_o   = (state_q == TP_RUN) && (full_i || budget_out);
  assign run_o       = (state_q == TP_RUN);
  assign collect_o   = collect_q;
  assign done_o      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TP_IDLE;
      cnt_q     <= '0;
      collect_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      collect_q <= start_evt_o;
      done_q    <= end_evt_o;
      if (start_evt_o) begin
        state_q <= TP_RUN;
        cnt_q   <= '0;
      end else if (end_evt_o) begin
        state_q <= TP_IDLE;
      end else if (state_q == TP_RUN) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_collect_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    collect_o |=> !collect_o);
  p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TP_RUN) |=> !collect_o);
  p_full_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && full_i) |=> !run_o);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !run_o);
  p_timer_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && timeout_i != '0) |-> (cnt_q < timeout_i));

endmodule

// File: rtl/tp_report_intake.sv
module tp_report_intake
  import thermo_poll_pkg::*;
#(
  parameter int unsigned CORE_UNITS = 4,
  parameter int unsigned CORE_SENS  = 8,
  parameter int unsigned HUB_SENS   = 6,
  parameter int unsigned CODE_W     = 9,
  parameter int unsigned UNIT_W     = 3,
  parameter int unsigned SENS_W     = 3,
  localparam int unsigned NUM_UNITS = CORE_UNITS + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear_i,
  input  logic                        take_i,
  input  logic [UNIT_W-1:0]           unit_i,
  input  logic [SENS_W-1:0]           sensor_i,
  input  logic [CODE_W-1:0]           code_i,
  input  logic [UNIT_W-1:0]           rd_unit_i,
  input  logic [SENS_W-1:0]           rd_sensor_i,
  output logic [CODE_W-1:0]           rd_code_o,
  output logic                        good_o,
  output logic                        proto_err_o,
  output logic [NUM_UNITS-1:0]        unit_done_o,
  output logic                        full_o,
  output logic [NUM_UNITS*CODE_W-1:0] run_max_o
);

  localparam int unsigned SLOTS = (CORE_SENS > HUB_SENS) ? CORE_SENS : HUB_SENS;

  logic [CODE_W-1:0] tbl_q  [NUM_UNITS][SLOTS];
  logic              got_q  [NUM_UNITS][SLOTS];
  logic [CODE_W-1:0] rmax_q [NUM_UNITS];
  logic              perr_q;
  logic              pair_ok;

  assign pair_ok     = tp_pair_wanted(32'(unit_i), 32'(sensor_i), CORE_UNITS, CORE_SENS, HUB_SENS);
  assign good_o      = take_i && pair_ok;
  assign proto_err_o = perr_q;
  assign full_o      = &unit_done_o;

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      unit_done_o[u] = 1'b1;
      for (int s = 0; s < SLOTS; s++)
        if (tp_pair_wanted(u, s, CORE_UNITS, CORE_SENS, HUB_SENS) && !got_q[u][s])
          unit_done_o[u] = 1'b0;
    end
  end

  always_comb begin
    rd_code_o = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      for (int s = 0; s < SLOTS; s++)
        if (rd_unit_i == UNIT_W'(u) && rd_sensor_i == SENS_W'(s) &&
            tp_pair_wanted(u, s, CORE_UNITS, CORE_SENS, HUB_SENS))
          rd_code_o = tbl_q[u][s];
  end

  genvar gu;
  generate
    for (gu = 0; gu < NUM_UNITS; gu++) begin : g_unit
      assign run_max_o[gu*CODE_W +: CODE_W] = rmax_q[gu];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rmax_q[gu] <= '0;
          for (int s = 0; s < SLOTS; s++) begin
            got_q[gu][s] <= 1'b0;
            tbl_q[gu][s] <= '0;
          end
        end else if (clear_i) begin
          rmax_q[gu] <= '0;
          for (int s = 0; s < SLOTS; s++) got_q[gu][s] <= 1'b0;
        end else if (good_o && unit_i == UNIT_W'(gu)) begin
          if (code_i > rmax_q[gu]) rmax_q[gu] <= code_i;
          for (int s = 0; s < SLOTS; s++)
            if (sensor_i == SENS_W'(s)) begin
              got_q[gu][s] <= 1'b1;
              tbl_q[gu][s] <= code_i;
            end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  perr_q <= 1'b0;
    else if (clear_i)            perr_q <= 1'b0;
    else if (take_i && !pair_ok) perr_q <= 1'b1;
  end

  p_drop_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !good_o) |=> proto_err_o);
  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !full_o);
  p_err_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err_o && !clear_i) |=> proto_err_o);

endmodule

// File: rtl/tp_result_agg.sv
module tp_result_agg #(
  parameter int unsigned NUM_UNITS = 5,
  parameter int unsigned CODE_W    = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_evt_i,
  input  logic                        end_evt_i,
  input  logic [NUM_UNITS-1:0]        unit_done_i,
  input  logic [NUM_UNITS*CODE_W-1:0] run_max_i,
  input  logic                        good_i,
  input  logic [CODE_W-1:0]           code_i,
  input  logic [CODE_W-1:0]           thresh_i,
  output logic [NUM_UNITS*CODE_W-1:0] max_o,
  output logic [NUM_UNITS-1:0]        tmo_o,
  output logic                        alarm_o
);

  logic [NUM_UNITS*CODE_W-1:0] max_q;
  logic [NUM_UNITS-1:0]        tmo_q;
  logic                        alarm_q;
  logic                        hot_hit;

  assign hot_hit = good_i && (code_i >= thresh_i);
  assign max_o   = max_q;
  assign tmo_o   = tmo_q;
  assign alarm_o = alarm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q   <= '0;
      tmo_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (hot_hit) alarm_q <= 1'b1;
      if (start_evt_i) begin
        tmo_q <= '0;
      end else if (end_evt_i) begin
        tmo_q <= ~unit_done_i;
        max_q <= run_max_i;
      end
    end
  end

  p_alarm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |=> alarm_o);
  p_hot_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hot_hit |=> alarm_o);
  p_tmo_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_evt_i && !end_evt_i) |=> $stable(tmo_o));

endmodule

// File: rtl/thermo_poll_ctrl.sv
module thermo_poll_ctrl #(
  parameter int unsigned CORE_UNITS = 4,
  parameter int unsigned CORE_SENS  = 8,
  parameter int unsigned HUB_SENS   = 6,
  parameter int unsigned CODE_W     = 9,
  parameter int unsigned TMO_W      = 16,
  localparam int unsigned NUM_UNITS = CORE_UNITS + 1,
  localparam int unsigned UNIT_W    = $clog2(NUM_UNITS),
  localparam int unsigned SENS_W    = $clog2(CORE_SENS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_i,
  input  logic                        start_i,
  input  logic [TMO_W-1:0]            timeout_i,
  input  logic [CODE_W-1:0]           thresh_i,
  output logic [NUM_UNITS-1:0]        collect_o,
  input  logic                        rpt_valid_i,
  output logic                        rpt_ready_o,
  input  logic [UNIT_W-1:0]           rpt_unit_i,
  input  logic [SENS_W-1:0]           rpt_sensor_i,
  input  logic [CODE_W-1:0]           rpt_code_i,
  input  logic [UNIT_W-1:0]           rd_unit_i,
  input  logic [SENS_W-1:0]           rd_sensor_i,
  output logic [CODE_W-1:0]           rd_code_o,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [NUM_UNITS-1:0]        tmo_o,
  output logic [NUM_UNITS*CODE_W-1:0] max_o,
  output logic                        proto_err_o,
  output logic                        alarm_o
);

  logic                        start_evt, end_evt, run, collect_one, full, take, good;
  logic [NUM_UNITS-1:0]        unit_done;
  logic [NUM_UNITS*CODE_W-1:0] run_max;

  assign rpt_ready_o = run && !end_evt;
  assign take        = rpt_valid_i && rpt_ready_o;
  assign busy_o      = run;
  assign collect_o   = {NUM_UNITS{collect_one}};

  tp_round_fsm #(.TMO_W(TMO_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trigger_i(tick_i | start_i), .full_i(full),
    .timeout_i(timeout_i), .start_evt_o(start_evt), .end_evt_o(end_evt),
    .run_o(run), .collect_o(collect_one), .done_o(done_o)
  );

  tp_report_intake #(
    .CORE_UNITS(CORE_UNITS), .CORE_SENS(CORE_SENS), .HUB_SENS(HUB_SENS),
    .CODE_W(CODE_W), .UNIT_W(UNIT_W), .SENS_W(SENS_W)
  ) u_intake (
    .clk(clk), .rst_n(rst_n), .clear_i(start_evt), .take_i(take),
    .unit_i(rpt_unit_i), .sensor_i(rpt_sensor_i), .code_i(rpt_code_i),
    .rd_unit_i(rd_unit_i), .rd_sensor_i(rd_sensor_i), .rd_code_o(rd_code_o),
    .good_o(good), .proto_err_o(proto_err_o), .unit_done_o(unit_done),
    .full_o(full), .run_max_o(run_max)
  );

  tp_result_agg #(.NUM_UNITS(NUM_UNITS), .CODE_W(CODE_W)) u_agg (
    .clk(clk), .rst_n(rst_n), .start_evt_i(start_evt), .end_evt_i(end_evt),
    .unit_done_i(unit_done), .run_max_i(run_max), .good_i(good),
    .code_i(rpt_code_i), .thresh_i(thresh_i), .max_o(max_o), .tmo_o(tmo_o),
    .alarm_o(alarm_o)
  );

  p_ready_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_ready_o |-> busy_o);
  p_collect_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> collect_o[0]);

endmodule

// File: tb/thermo_poll_ctrl_tb.sv
module thermo_poll_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, start_i = 1'b0;
  logic [15:0] timeout_i = 16'd1000;
  logic [8:0]  thresh_i = 9'd300;
  logic [4:0]  collect_o;
  logic        rpt_valid_i = 1'b0, rpt_ready_o;
  logic [2:0]  rpt_unit_i = '0, rpt_sensor_i = '0;
  logic [8:0]  rpt_code_i = '0;
  logic [2:0]  rd_unit_i = '0, rd_sensor_i = '0;
  logic [8:0]  rd_code_o;
  logic        busy_o, done_o, proto_err_o, alarm_o;
  logic [4:0]  tmo_o;
  logic [44:0] max_o;

  always #4 clk = ~clk;

  thermo_poll_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start_i),
    .timeout_i(timeout_i), .thresh_i(thresh_i), .collect_o(collect_o),
    .rpt_valid_i(rpt_valid_i), .rpt_ready_o(rpt_ready_o), .rpt_unit_i(rpt_unit_i),
    .rpt_sensor_i(rpt_sensor_i), .rpt_code_i(rpt_code_i), .rd_unit_i(rd_unit_i),
    .rd_sensor_i(rd_sensor_i), .rd_code_o(rd_code_o), .busy_o(busy_o),
    .done_o(done_o), .tmo_o(tmo_o), .max_o(max_o), .proto_err_o(proto_err_o),
    .alarm_o(alarm_o)
  );

  typedef struct { int u; int s; int code; } item_t;
  item_t sb_q[$];
  int    exp_max[5];
  int    errs = 0, checks = 0, cyc = 0, start_cyc = 0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // Driver: caller is at a falling edge; one report per cycle.
  task automatic send(int u, int s, int code, bit stored);
    item_t it;
    rpt_valid_i  = 1'b1;
    rpt_unit_i   = 3'(u);
    rpt_sensor_i = 3'(s);
    rpt_code_i   = 9'(code);
    @(posedge clk);
    @(negedge clk);
    rpt_valid_i = 1'b0;
    if (stored) begin
      it.u = u; it.s = s; it.code = code;
      sb_q.push_back(it);
      if (code > exp_max[u]) exp_max[u] = code;
    end
  endtask

  task automatic begin_round(bit use_tick);
    if (use_tick) tick_i = 1'b1; else start_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; start_i = 1'b0;
    start_cyc = cyc;
    for (int u = 0; u < 5; u++) exp_max[u] = 0;
    chk("R1", "collect_o after trigger", int'(collect_o), 31);
    chk("R1", "busy_o after trigger", int'(busy_o), 1);
    chk("R3", "rpt_ready_o in round", int'(rpt_ready_o), 1);
  endtask

  // Monitor: pops the scoreboard once the round has ended.
  task automatic drain_check(string req);
    while (sb_q.size() > 0) begin
      item_t it = sb_q.pop_front();
      rd_unit_i   = 3'(it.u);
      rd_sensor_i = 3'(it.s);
      #1;
      chk(req, $sformatf("reading u%0d s%0d", it.u, it.s), int'(rd_code_o), it.code);
    end
    for (int u = 0; u < 5; u++)
      chk("R6", $sformatf("max of unit %0d", u), int'(max_o[u*9 +: 9]), exp_max[u]);
  endtask

  task automatic expect_done_next();
    chk("R5", "done_o before due", int'(done_o), 0);
    chk("R5", "busy_o before due", int'(busy_o), 1);
    @(negedge clk);
    chk("R5", "done_o when due", int'(done_o), 1);
    chk("R5", "busy_o at end", int'(busy_o), 0);
    chk("R7", "tmo_o after full round", int'(tmo_o), 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errs++;
    $display("FAIL watchdog: run did not end");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "busy_o", int'(busy_o), 0);
    chk("R9", "collect_o", int'(collect_o), 0);
    chk("R9", "rpt_ready_o", int'(rpt_ready_o), 0);
    chk("R9", "done_o", int'(done_o), 0);
    chk("R9", "tmo_o", int'(tmo_o), 0);
    chk("R9", "max_o", int'(max_o != '0), 0);
    chk("R9", "proto_err_o", int'(proto_err_o), 0);
    chk("R9", "alarm_o", int'(alarm_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // Round A: unit-major order, start_i trigger, start retried mid-round (R2)
    begin_round(1'b0);
    @(negedge clk);
    chk("R1", "collect_o pulse width", int'(collect_o), 0);
    for (int u = 0; u < 5; u++)
      for (int s = 0; s < (u < 4 ? 8 : 6); s++) begin
        if (u == 2 && s == 4) begin
          start_i = 1'b1;
          @(negedge clk);
          start_i = 1'b0;
          chk("R2", "no collect while busy", int'(collect_o), 0);
          chk("R2", "still busy", int'(busy_o), 1);
        end
        send(u, s, (u * 37 + s * 11 + 1) % 512, 1'b1);
      end
    expect_done_next();
    chk("R8", "alarm below threshold", int'(alarm_o), 0);
    drain_check("R3");
    @(negedge clk);
    chk("R2", "no restart after round", int'(busy_o), 0);

    // Round C: invalid reports, then timeout with units 2..4 missing
    timeout_i = 16'd40;
    begin_round(1'b0);
    send(4, 6, 511, 1'b0);
    chk("R4", "proto_err after hub s6", int'(proto_err_o), 1);
    chk("R8", "dropped code raises no alarm", int'(alarm_o), 0);
    send(5, 0, 400, 1'b0);
    chk("R8", "dropped unit 5 raises no alarm", int'(alarm_o), 0);
    for (int u = 0; u < 2; u++)
      for (int s = 0; s < 8; s++)
        send(u, s, (u * 29 + s * 13 + 7) % 256, 1'b1);
    while (!done_o && cyc - start_cyc < 200) begin
      if (cyc - start_cyc == 39)
        chk("R7", "done_o one cycle early", int'(done_o), 0);
      @(negedge clk);
    end
    chk("R7", "timeout distance", cyc - start_cyc, 40);
    chk("R7", "tmo_o missing units", int'(tmo_o), 5'b11100);
    chk("R4", "proto_err held", int'(proto_err_o), 1);
    drain_check("R6");
    timeout_i = 16'd1000;
    @(negedge clk);

    // Round B: tick trigger, sensor-major order, threshold boundary
    begin_round(1'b1);
    chk("R4", "proto_err cleared at start", int'(proto_err_o), 0);
    chk("R7", "tmo_o cleared at start", int'(tmo_o), 0);
    for (int s = 0; s < 8; s++)
      for (int u = 0; u < 5; u++)
        if (!(u == 4 && s >= 5))
          send(u, s, (u * 53 + s * 7 + 20) % 512, 1'b1);
    chk("R8", "alarm before equal code", int'(alarm_o), 0);
    send(4, 5, 300, 1'b1);
    chk("R8", "alarm on code equal threshold", int'(alarm_o), 1);
    expect_done_next();
    drain_check("R3");
    @(negedge clk);
    chk("R8", "alarm sticky", int'(alarm_o), 1);
    summary();
  end

endmodule